// File: doc/BRIEF.md
# Directory Cache Line Controller

This block is the cache-side coherence controller for a single cache line in a machine whose caches have no shared bus. They talk to the home node of each memory block over point-to-point messages. The line holds one block of `WORDS` words, its block address (tag) and a coherence state: Invalid, Shared or Exclusive. The processor issues word reads and writes. The controller either serves them from the line or sends a request message to the home node. A processor that misses stays blocked until the home node returns the whole block.

The home node can also send the line invalidate, fetch and fetch-and-invalidate messages. The controller answers with a write-back message that carries the block whenever the line holds the only valid copy. When a processor access to a different block would displace an Exclusive line, the controller first writes the old block back and then asks for the new one.

Only one message leaves the controller per cycle, and only one arrives per cycle. An incoming home message always wins over a processor request in the same cycle. The processor is held until the message has been handled.

Top module: `dir_line_ctrl`

## Requirements
- R1: After reset the line state is Invalid (code 0), `cpu_done` is low and `out_valid` is low.
- R2: A read to a line that does not hold the block sends, one cycle later, a read-miss message (kind 0) carrying `NODE_ID` and the block address (`cpu_addr` above the low log2(WORDS) word-offset bits).
- R3: A write to a line that is Invalid, or Shared with the same block, sends a write-miss message (kind 1) with the block address.
- R4: Once a miss message has been sent, `cpu_done` stays low until a data reply (incoming kind 3) for the same block arrives.
- R5: A data reply for a pending read fills the block, moves the line to Shared (code 1) and returns the addressed word on `cpu_rdata` with `cpu_done` one cycle later.
- R6: A data reply for a pending write loads the full block, replaces the addressed word with the written word, moves the line to Exclusive (code 2) and returns the written word.
- R7: An invalidate (incoming kind 0) for the block of a Shared line moves it to Invalid and sends no message.
- R8: A fetch (incoming kind 1) for the block of an Exclusive line sends a write-back (kind 2) with the block address and the full block, and moves the line to Shared.
- R9: A fetch-and-invalidate (incoming kind 2) for the block of an Exclusive line sends a write-back with address and block, and moves the line to Invalid.
- R10: An access to a different block while the line is Exclusive first sends a write-back of the old block, and sends the miss message for the new block one cycle later.
- R11: An incoming home message in the same cycle as a processor request is handled first, and the request is taken in a later cycle. Home messages that arrive during a pending miss are handled without completing the miss.
- R12: A read hit (Shared or Exclusive) and a write hit on an Exclusive line complete one cycle later with no message. Word bits in a block are packed with word 0 in the lowest `WORD_W` bits.
- R13: A home message whose address differs from the tag, or whose kind does not fit the line state, has no effect: no message is sent and the state is unchanged. A data reply to a different block does not complete a pending miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | BLK_AW+log2(WORDS) | Word address: block address above word offset |
| cpu_wdata | input | WORD_W | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Read word, or written word on a write |
| in_valid | input | 1 | Incoming home message valid |
| in_kind | input | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| in_addr | input | BLK_AW | Block address of the home message |
| in_data | input | WORDS*WORD_W | Block carried by a data reply |
| out_valid | output | 1 | Outgoing message valid for one cycle |
| out_kind | output | 2 | 0 read miss, 1 write miss, 2 data write-back |
| out_node | output | NODE_W | Requesting node number |
| out_addr | output | BLK_AW | Block address of the message |
| out_data | output | WORDS*WORD_W | Block for a write-back, zero otherwise |
| line_state | output | 2 | 0 Invalid, 1 Shared, 2 Exclusive |

## Verification
The bench builds the controller with four 16-bit words per block, a 6-bit block address and node number 5 on a 3-bit field. Four words allow a written word to be placed at a middle offset. The merge is then visible in a later write-back, with the reply's own words on both sides of it. The short block address keeps the tags for hit, conflict and mismatched-message cases easy to read. Distinct seeds per reply make every word of every block unique, so a stale or misplaced word shows up in the packed block.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHD = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        HM_INVAL     = 2'd0,
        HM_FETCH     = 2'd1,
        HM_FETCH_INV = 2'd2,
        HM_REPLY     = 2'd3
    } home_msg_e;

    typedef enum logic [1:0] {
        RQ_RD_MISS = 2'd0,
        RQ_WR_MISS = 2'd1,
        RQ_WRBACK  = 2'd2
    } req_msg_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_INVAL,
        ACT_FETCH,
        ACT_FETCH_INV,
        ACT_FILL
    } home_act_e;

    typedef enum logic {
        CT_IDLE,
        CT_WAIT
    } ctl_e;

endpackage

// File: rtl/dlc_home_dec.sv
module dlc_home_dec
    import dlc_pkg::*;
#(
    parameter int BLK_AW = 8
) (
    input  logic              msg_valid,
    input  home_msg_e         msg_kind,
    input  logic [BLK_AW-1:0] msg_addr,
    input  logic [BLK_AW-1:0] line_tag,
    input  line_st_e          line_st,
    input  logic              pending,
    output home_act_e         act
);
    logic match;

    always_comb begin
        match = (msg_addr == line_tag);
        act   = ACT_NONE;
        if (msg_valid && match) begin
            case (msg_kind)
                HM_INVAL:     if (line_st == LN_SHD) act = ACT_INVAL;
                HM_FETCH:     if (line_st == LN_EXC) act = ACT_FETCH;
                HM_FETCH_INV: if (line_st == LN_EXC) act = ACT_FETCH_INV;
                HM_REPLY:     if (pending)           act = ACT_FILL;
                default:      act = ACT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/dlc_line_store.sv
module dlc_line_store #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 16,
    localparam int OFF_W = $clog2(WORDS),
    localparam int BLK_W = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  logic [BLK_W-1:0]  fill_data,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [WORD_W-1:0] wr_word,
    output logic [BLK_W-1:0]  blk
);
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [WORD_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr_en && (wr_off == OFF_W'(i))) begin
                word_q <= wr_word;
            end else if (fill_en) begin
                word_q <= fill_data[i*WORD_W +: WORD_W];
            end
        end

        assign blk[i*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/dir_line_ctrl.sv
module dir_line_ctrl
    import dlc_pkg::*;
#(
    parameter int NODE_W  = 3,
    parameter int NODE_ID = 5,
    parameter int BLK_AW  = 6,
    parameter int WORDS   = 4,
    parameter int WORD_W  = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cpu_req,
    input  logic                             cpu_we,
    input  logic [BLK_AW+$clog2(WORDS)-1:0]  cpu_addr,
    input  logic [WORD_W-1:0]                cpu_wdata,
    output logic                             cpu_done,
    output logic [WORD_W-1:0]                cpu_rdata,
    input  logic                             in_valid,
    input  logic [1:0]                       in_kind,
    input  logic [BLK_AW-1:0]                in_addr,
    input  logic [WORDS*WORD_W-1:0]          in_data,
    output logic                             out_valid,
    output logic [1:0]                       out_kind,
    output logic [NODE_W-1:0]                out_node,
    output logic [BLK_AW-1:0]                out_addr,
    output logic [WORDS*WORD_W-1:0]          out_data,
    output logic [1:0]                       line_state
);
    localparam int OFF_W = $clog2(WORDS);
    localparam int BLK_W = WORDS * WORD_W;
    localparam int AW    = BLK_AW + OFF_W;

    ctl_e               ctl_q;
    line_st_e           st_q;
    logic [BLK_AW-1:0]  tag_q;
    logic               pend_we_q;
    logic [OFF_W-1:0]   pend_off_q;
    logic [WORD_W-1:0]  pend_wd_q;
    logic               done_q;
    logic [WORD_W-1:0]  rdata_q;
    logic               ov_q;
    req_msg_e           ok_q;
    logic [BLK_AW-1:0]  oa_q;
    logic [BLK_W-1:0]   od_q;

    home_act_e          act;
    logic [BLK_W-1:0]   blk_q;
    logic [BLK_AW-1:0]  cpu_blk;
    logic [OFF_W-1:0]   cpu_off;
    logic               hit;
    logic               cpu_take;
    logic               fill_en;
    logic               wr_en;
    logic [OFF_W-1:0]   wr_off;
    logic [WORD_W-1:0]  wr_word;

    dlc_home_dec #(.BLK_AW(BLK_AW)) u_dec (
        .msg_valid (in_valid),
        .msg_kind  (home_msg_e'(in_kind)),
        .msg_addr  (in_addr),
        .line_tag  (tag_q),
        .line_st   (st_q),
        .pending   (ctl_q == CT_WAIT),
        .act       (act)
    );

    dlc_line_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .fill_en   (fill_en),
        .fill_data (in_data),
        .wr_en     (wr_en),
        .wr_off    (wr_off),
        .wr_word   (wr_word),
        .blk       (blk_q)
    );

    // home messages take precedence; a completed request is not retaken
    always_comb begin
        cpu_blk  = cpu_addr[AW-1:OFF_W];
        cpu_off  = cpu_addr[OFF_W-1:0];
        hit      = (st_q != LN_INV) && (tag_q == cpu_blk);
        cpu_take = cpu_req && !done_q && (ctl_q == CT_IDLE) && !in_valid;
        fill_en  = (act == ACT_FILL);
        wr_en    = (fill_en && pend_we_q) ||
                   (cpu_take && cpu_we && hit && (st_q == LN_EXC));
        wr_off   = fill_en ? pend_off_q : cpu_off;
        wr_word  = fill_en ? pend_wd_q  : cpu_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= CT_IDLE;
            st_q       <= LN_INV;
            tag_q      <= '0;
            pend_we_q  <= 1'b0;
            pend_off_q <= '0;
            pend_wd_q  <= '0;
            done_q     <= 1'b0;
            rdata_q    <= '0;
            ov_q       <= 1'b0;
            ok_q       <= RQ_RD_MISS;
            oa_q       <= '0;
            od_q       <= '0;
        end else begin
            ov_q   <= 1'b0;
            done_q <= 1'b0;
            case (act)
                ACT_INVAL: st_q <= LN_INV;
                ACT_FETCH, ACT_FETCH_INV: begin
                    ov_q <= 1'b1;
                    ok_q <= RQ_WRBACK;
                    oa_q <= tag_q;
                    od_q <= blk_q;
                    st_q <= (act == ACT_FETCH) ? LN_SHD : LN_INV;
                end
                ACT_FILL: begin
                    ctl_q   <= CT_IDLE;
                    st_q    <= pend_we_q ? LN_EXC : LN_SHD;
                    done_q  <= 1'b1;
                    rdata_q <= pend_we_q ? pend_wd_q
                                         : in_data[pend_off_q*WORD_W +: WORD_W];
                end
                default: begin
                    if (cpu_take) begin
                        if (hit && (!cpu_we || st_q == LN_EXC)) begin
                            done_q  <= 1'b1;
                            rdata_q <= cpu_we ? cpu_wdata
                                              : blk_q[cpu_off*WORD_W +: WORD_W];
                        end else if (st_q == LN_EXC) begin
                            // conflicting block: write the owned copy back first
                            ov_q <= 1'b1;
                            ok_q <= RQ_WRBACK;
                            oa_q <= tag_q;
                            od_q <= blk_q;
                            st_q <= LN_INV;
                        end else begin
                            ov_q       <= 1'b1;
                            ok_q       <= cpu_we ? RQ_WR_MISS : RQ_RD_MISS;
                            oa_q       <= cpu_blk;
                            od_q       <= '0;
                            tag_q      <= cpu_blk;
                            st_q       <= LN_INV;
                            ctl_q      <= CT_WAIT;
                            pend_we_q  <= cpu_we;
                            pend_off_q <= cpu_off;
                            pend_wd_q  <= cpu_wdata;
                        end
                    end
                end
            endcase
        end
    end

    assign cpu_done   = done_q;
    assign cpu_rdata  = rdata_q;
    assign out_valid  = ov_q;
    assign out_kind   = ok_q;
    assign out_node   = NODE_W'(NODE_ID);
    assign out_addr   = oa_q;
    assign out_data   = od_q;
    assign line_state = st_q;

    // R4
    wait_block_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q == CT_WAIT && act != ACT_FILL) |=> !cpu_done);

    // R2
    miss_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind != RQ_WRBACK) |-> (ctl_q == CT_WAIT));

    // R10
    evict_order_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind != RQ_WRBACK) |-> ($past(st_q) != LN_EXC));

    // R7
    inval_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_INVAL) |=> (!out_valid && line_state == LN_INV));

    // R8
    fetch_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_FETCH) |=> (out_valid && out_kind == RQ_WRBACK &&
                                out_addr == $past(in_addr) && line_state == LN_SHD));

    // R9
    fetch_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_FETCH_INV) |=> (out_valid && out_kind == RQ_WRBACK &&
                                    line_state == LN_INV));

    // R6
    wr_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_FILL && pend_we_q) |=> (cpu_done && line_state == LN_EXC));
endmodule

// File: tb/tb_dir_line_ctrl.sv
module tb_dir_line_ctrl;
    localparam int NODE_W = 3;
    localparam int NODE_ID = 5;
    localparam int BLK_AW = 6;
    localparam int WORDS = 4;
    localparam int WORD_W = 16;
    localparam int BLK_W = WORDS * WORD_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [7:0]        cpu_addr = '0;
    logic [15:0]       cpu_wdata = '0;
    logic              cpu_done;
    logic [15:0]       cpu_rdata;
    logic              in_valid = 1'b0;
    logic [1:0]        in_kind = '0;
    logic [5:0]        in_addr = '0;
    logic [BLK_W-1:0]  in_data = '0;
    logic              out_valid;
    logic [1:0]        out_kind;
    logic [2:0]        out_node;
    logic [5:0]        out_addr;
    logic [BLK_W-1:0]  out_data;
    logic [1:0]        line_state;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    dir_line_ctrl #(.NODE_W(NODE_W), .NODE_ID(NODE_ID), .BLK_AW(BLK_AW),
                    .WORDS(WORDS), .WORD_W(WORD_W)) dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .in_valid(in_valid), .in_kind(in_kind),
        .in_addr(in_addr), .in_data(in_data), .out_valid(out_valid),
        .out_kind(out_kind), .out_node(out_node), .out_addr(out_addr),
        .out_data(out_data), .line_state(line_state)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] mkblk(input logic [15:0] s);
        mkblk = {s + 16'd3, s + 16'd2, s + 16'd1, s};
    endfunction

    task automatic cpu_go(input logic we, input logic [5:0] blk, input logic [1:0] off,
                          input logic [15:0] wd);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = {blk, off}; cpu_wdata = wd;
    endtask

    task automatic home(input logic [1:0] k, input logic [5:0] a, input logic [63:0] d);
        in_valid = 1'b1; in_kind = k; in_addr = a; in_data = d;
    endtask

    task automatic home_pulse(input logic [1:0] k, input logic [5:0] a, input logic [63:0] d);
        home(k, a, d);
        step();
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 state", 64'(line_state), 64'd0);
        check("R1 done", 64'(cpu_done), 64'd0);
        check("R1 out_valid", 64'(out_valid), 64'd0);
    endtask

    task automatic t_read_miss();
        step();
        cpu_go(1'b0, 6'd3, 2'd2, 16'h0);
        step();
        check("R2 out_valid", 64'(out_valid), 64'd1);
        check("R2 kind", 64'(out_kind), 64'd0);
        check("R2 node", 64'(out_node), 64'd5);
        check("R2 addr", 64'(out_addr), 64'd3);
        check("R4 done while pending", 64'(cpu_done), 64'd0);
        step();
        check("R4 still blocked", 64'(cpu_done), 64'd0);
        check("R4 no repeat msg", 64'(out_valid), 64'd0);
        home_pulse(2'd3, 6'd3, mkblk(16'h0100));
        cpu_req = 1'b0;
        check("R5 done", 64'(cpu_done), 64'd1);
        check("R5 rdata", 64'(cpu_rdata), 64'h0102);
        check("R5 state shared", 64'(line_state), 64'd1);
    endtask

    task automatic t_read_hit();
        step();
        cpu_go(1'b0, 6'd3, 2'd1, 16'h0);
        step();
        cpu_req = 1'b0;
        check("R12 hit done", 64'(cpu_done), 64'd1);
        check("R12 hit rdata", 64'(cpu_rdata), 64'h0101);
        check("R12 hit no msg", 64'(out_valid), 64'd0);
    endtask

    task automatic t_invalidate();
        step();
        home_pulse(2'd0, 6'd4, '0);
        check("R13 other addr no msg", 64'(out_valid), 64'd0);
        check("R13 other addr state", 64'(line_state), 64'd1);
        home_pulse(2'd1, 6'd3, '0);
        check("R13 fetch on shared no msg", 64'(out_valid), 64'd0);
        check("R13 fetch on shared state", 64'(line_state), 64'd1);
        home_pulse(2'd0, 6'd3, '0);
        check("R7 no msg", 64'(out_valid), 64'd0);
        check("R7 state invalid", 64'(line_state), 64'd0);
    endtask

    task automatic t_write_invalid();
        step();
        cpu_go(1'b1, 6'd3, 2'd1, 16'hBEEF);
        step();
        check("R3 wmiss valid", 64'(out_valid), 64'd1);
        check("R3 wmiss kind", 64'(out_kind), 64'd1);
        check("R3 wmiss addr", 64'(out_addr), 64'd3);
        home_pulse(2'd3, 6'd3, mkblk(16'h0200));
        cpu_req = 1'b0;
        check("R6 done", 64'(cpu_done), 64'd1);
        check("R6 rdata", 64'(cpu_rdata), 64'hBEEF);
        check("R6 state exclusive", 64'(line_state), 64'd2);
        step();
        home_pulse(2'd1, 6'd3, '0);
        check("R8 wb valid", 64'(out_valid), 64'd1);
        check("R8 wb kind", 64'(out_kind), 64'd2);
        check("R8 wb addr", 64'(out_addr), 64'd3);
        check("R6 R8 merged block", out_data, {16'h0203, 16'h0202, 16'hBEEF, 16'h0200});
        check("R8 state shared", 64'(line_state), 64'd1);
    endtask

    task automatic t_write_shared();
        step();
        cpu_go(1'b1, 6'd3, 2'd0, 16'h1111);
        step();
        check("R3 upgrade kind", 64'(out_kind), 64'd1);
        check("R3 upgrade valid", 64'(out_valid), 64'd1);
        home_pulse(2'd3, 6'd3, mkblk(16'h0300));
        cpu_req = 1'b0;
        check("R6 upgrade state", 64'(line_state), 64'd2);
        step();
        cpu_go(1'b1, 6'd3, 2'd3, 16'h4444);
        step();
        cpu_req = 1'b0;
        check("R12 write hit done", 64'(cpu_done), 64'd1);
        check("R12 write hit no msg", 64'(out_valid), 64'd0);
        step();
        home_pulse(2'd2, 6'd3, '0);
        check("R9 wb kind", 64'(out_kind), 64'd2);
        check("R9 wb valid", 64'(out_valid), 64'd1);
        check("R9 wb data", out_data, {16'h4444, 16'h0302, 16'h0301, 16'h1111});
        check("R9 state invalid", 64'(line_state), 64'd0);
    endtask

    task automatic t_evict();
        step();
        cpu_go(1'b1, 6'd7, 2'd2, 16'h7777);
        step();
        home_pulse(2'd3, 6'd7, mkblk(16'h0700));
        cpu_req = 1'b0;
        check("R6 evict setup", 64'(line_state), 64'd2);
        step();
        cpu_go(1'b0, 6'd9, 2'd0, 16'h0);
        step();
        check("R10 wb first kind", 64'(out_kind), 64'd2);
        check("R10 wb first addr", 64'(out_addr), 64'd7);
        check("R10 wb data", out_data, {16'h0703, 16'h7777, 16'h0701, 16'h0700});
        check("R10 not done", 64'(cpu_done), 64'd0);
        step();
        check("R10 then miss kind", 64'(out_kind), 64'd0);
        check("R10 then miss addr", 64'(out_addr), 64'd9);
        check("R10 then miss valid", 64'(out_valid), 64'd1);
        home_pulse(2'd3, 6'd9, mkblk(16'h0900));
        cpu_req = 1'b0;
        check("R5 evict read data", 64'(cpu_rdata), 64'h0900);
        check("R5 evict state", 64'(line_state), 64'd1);
    endtask

    task automatic t_priority();
        step();
        cpu_go(1'b0, 6'd12, 2'd1, 16'h0);
        home(2'd0, 6'd9, '0);
        step();
        in_valid = 1'b0;
        check("R11 home first no msg", 64'(out_valid), 64'd0);
        check("R11 home first state", 64'(line_state), 64'd0);
        check("R11 cpu waits", 64'(cpu_done), 64'd0);
        step();
        check("R11 cpu taken later", 64'(out_kind), 64'd0);
        check("R11 cpu miss addr", 64'(out_addr), 64'd12);
        home_pulse(2'd1, 6'd12, '0);
        check("R11 fetch while pending no msg", 64'(out_valid), 64'd0);
        check("R11 R4 still pending", 64'(cpu_done), 64'd0);
        home_pulse(2'd3, 6'd13, mkblk(16'h0D00));
        check("R13 wrong reply no done", 64'(cpu_done), 64'd0);
        check("R13 wrong reply state", 64'(line_state), 64'd0);
        home_pulse(2'd3, 6'd12, mkblk(16'h0C00));
        cpu_req = 1'b0;
        check("R5 R11 done", 64'(cpu_done), 64'd1);
        check("R5 R11 rdata", 64'(cpu_rdata), 64'h0C01);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_read_miss();
        t_read_hit();
        t_invalidate();
        t_write_invalid();
        t_write_shared();
        t_evict();
        t_priority();
        step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule